// File: doc/BRIEF.md
# Anchor Picture Display Scheduler

This block picks the frame store that the display path reads from, in a video decoder with three frame stores. Two of the stores take turns holding reference (anchor) pictures, I or P, and the third holds B pictures. The decoder reports each finished picture as a one-cycle event that carries its type and its store index. The scheduler releases pictures for display in presentation order. An anchor picture waits until the next anchor arrives, while a B picture is released as soon as it is decoded. Released pictures are shown one frame at a time, as a first field and then a last field. Changes of store are made only at a field-sync pulse that opens a first field.

A sequence end code releases any anchor that is still waiting. Once the last released picture is on screen, the display freezes on it until a sequence start code arrives. The end code also sets an interrupt status bit. An active-low interrupt line reports that bit unless a mask bit hides it. The host can also put the display into a stepping mode. In that mode the display advances by one picture for each step bit the host sets, and the block clears the step bit itself after the advance.

Top module: `anchor_disp_sched`

## Requirements
- R1: A decoded anchor picture (kind code 0 = I, 1 = P) is not released for display until the next anchor is decoded or a sequence end code arrives. The display therefore keeps repeating the previous picture while the newest anchor is still held.
- R2: A B picture (kind code 2) is released as soon as it is decoded. Released pictures are shown in release order. Kind code 3 is ignored. At most one of decode-done, sequence-end and sequence-start is high in any cycle.
- R3: `disp_last` toggles on every `fsync` pulse, and reset leaves it at 1 so that the first pulse opens a first field (0). `disp_store` changes only on a pulse that opens a first field, and only when a released picture is waiting.
- R4: A sequence end code releases the anchor that is being held, so that it is shown at the next first-field boundary without waiting for another anchor.
- R5: After a sequence end code, once every released picture has been shown, `frozen` goes to 1. While it is 1, `disp_store` holds its value and pictures decoded in the meantime are not shown, but `disp_last` keeps toggling.
- R6: A sequence start code clears `frozen`. Display then resumes with the pictures released since then, in normal order.
- R7: A sequence end code sets the status bit at bit 0 of address 0. A host write to address 0 with bit 0 at 1 clears it, and a write with bit 0 at 0 leaves it set. If a set and a clear arrive in the same cycle, the set wins.
- R8: `irq_n` is 0 exactly when the status bit is 1 and the mask bit (address 1, bit 2) is 0.
- R9: When the step-mode bit (address 1, bit 0) is 1, the display advances only while the step bit (address 1, bit 1) is 1. The block clears the step bit after one advance, and that clear shows on readback. If step mode is off, the step bit has no effect.
- R10: After reset, `disp_store` is 0, `disp_last` is 1, `frozen` is 0, `irq_n` is 1, and both registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_done | input | 1 | One-cycle pulse: a picture finished decoding |
| dec_kind | input | 2 | Picture kind: 0 I, 1 P, 2 B, 3 ignored |
| dec_store | input | STORE_W | Store index the picture was decoded into |
| seq_end | input | 1 | Sequence end code detected (pulse) |
| seq_start | input | 1 | Sequence start code detected (pulse) |
| fsync | input | 1 | Field-sync pulse from the output timing |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Register address: 0 status, 1 control |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Readback of the addressed register (combinational) |
| disp_store | output | STORE_W | Store index currently shown |
| disp_last | output | 1 | 0 = first field, 1 = last field |
| frozen | output | 1 | Display is frozen after a sequence end |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check that the shown store only changes at a pulse that opens a first field, that the field indicator toggles on each pulse, that a frozen display holds its store, that a held anchor stays held, that the end code empties the holding slot and sets the status bit, that the step bit drops only after an advance or a host write, and that the queue never overflows. Some behaviour can only be shown by the directed scenarios, because it depends on ordering across many pictures. This covers decode-to-display reordering, the flush of a held anchor after an end code, the point at which the freeze takes hold, the resumption after a start code, the effect of the mask and of write-one-to-clear on the interrupt line, and the self-clearing single step seen through register readback.

// File: rtl/ads_pkg.sv
package ads_pkg;
   typedef enum logic [1:0] {
      PIC_I   = 2'd0,
      PIC_P   = 2'd1,
      PIC_B   = 2'd2,
      PIC_NONE = 2'd3
   } pic_kind_e;

   localparam int REG_STATUS = 0;
   localparam int REG_CTRL   = 1;

   localparam int CTRL_STEP_MODE = 0;
   localparam int CTRL_STEP      = 1;
   localparam int CTRL_MASK      = 2;
   localparam int STAT_SEQ_END   = 0;
endpackage

// File: rtl/ads_anchor_hold.sv
module ads_anchor_hold
   import ads_pkg::*;
#(
   parameter int STORE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_done,
   input  logic [1:0]         dec_kind,
   input  logic [STORE_W-1:0] dec_store,
   input  logic               seq_end,
   output logic               rel_push,
   output logic [STORE_W-1:0] rel_store
);
   logic               held_v;
   logic [STORE_W-1:0] held_store;
   logic               got_anchor;
   logic               got_b;

   always_comb begin
      got_anchor = dec_done && (dec_kind == PIC_I || dec_kind == PIC_P);
      got_b      = dec_done && (dec_kind == PIC_B);
      rel_push   = got_b || (held_v && (got_anchor || seq_end));
      rel_store  = got_b ? dec_store : held_store;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v     <= 1'b0;
         held_store <= '0;
      end else if (got_anchor) begin
         held_v     <= 1'b1;
         held_store <= dec_store;
      end else if (seq_end) begin
         held_v     <= 1'b0;
      end
   end

   // R1
   anchor_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      got_anchor |=> held_v && held_store == $past(dec_store));

   // R4
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end |=> !held_v);
endmodule

// File: rtl/ads_ready_fifo.sv
module ads_ready_fifo #(
   parameter int STORE_W = 2,
   parameter int DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [STORE_W-1:0] push_data,
   input  logic               pop,
   output logic [STORE_W-1:0] head,
   output logic               empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [STORE_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]   count;
   logic               full, do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      empty   = (count == '0);
      full    = (count == CNT_W'(DEPTH));
      do_pop  = pop && !empty;
      do_push = push && (!full || do_pop);
      head    = slots[rd_ptr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + CNT_W'(1);
         else if (do_pop && !do_push) count <= count - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= push_data;
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
endmodule

// File: rtl/ads_field_seq.sv
module ads_field_seq #(
   parameter int STORE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync,
   input  logic               q_empty,
   input  logic [STORE_W-1:0] q_head,
   input  logic               q_push,
   input  logic               seq_end,
   input  logic               seq_start,
   input  logic               step_mode,
   input  logic               step_req,
   output logic               q_pop,
   output logic               step_done,
   output logic [STORE_W-1:0] disp_store,
   output logic               disp_last,
   output logic               frozen
);
   logic end_wait;
   logic may_advance;

   always_comb begin
      may_advance = !frozen && (!step_mode || step_req);
      q_pop       = fsync && disp_last && may_advance && !q_empty;
      step_done   = q_pop && step_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_last  <= 1'b1;
         disp_store <= '0;
      end else if (fsync) begin
         disp_last <= !disp_last;
         if (q_pop) disp_store <= q_head;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_wait <= 1'b0;
         frozen   <= 1'b0;
      end else if (seq_start) begin
         end_wait <= 1'b0;
         frozen   <= 1'b0;
      end else if (seq_end) begin
         end_wait <= 1'b1;
      end else if (end_wait && q_empty && !q_push) begin
         end_wait <= 1'b0;
         frozen   <= 1'b1;
      end
   end

   // R3
   store_at_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fsync && disp_last) |=> $stable(disp_store));

   // R3
   field_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (disp_last != $past(disp_last)));

   // R5
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !seq_start) |=> (frozen && $stable(disp_store)));
endmodule

// File: rtl/ads_host_regs.sv
module ads_host_regs
   import ads_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              seq_end,
   input  logic              step_done,
   output logic [DATA_W-1:0] host_rdata,
   output logic              step_mode,
   output logic              step_req,
   output logic              irq_n
);
   logic stat_end;
   logic irq_mask;
   logic wr_stat, wr_ctrl;
   wire  unused_wdata = ^host_wdata;

   always_comb begin
      wr_stat = host_wr && (host_addr == ADDR_W'(REG_STATUS));
      wr_ctrl = host_wr && (host_addr == ADDR_W'(REG_CTRL));
      irq_n   = !(stat_end && !irq_mask);
      host_rdata = '0;
      if (host_addr == ADDR_W'(REG_STATUS)) begin
         host_rdata[STAT_SEQ_END] = stat_end;
      end else if (host_addr == ADDR_W'(REG_CTRL)) begin
         host_rdata[CTRL_STEP_MODE] = step_mode;
         host_rdata[CTRL_STEP]      = step_req;
         host_rdata[CTRL_MASK]      = irq_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_end <= 1'b0;
      end else if (seq_end) begin
         stat_end <= 1'b1;
      end else if (wr_stat && host_wdata[STAT_SEQ_END]) begin
         stat_end <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_mode <= 1'b0;
         step_req  <= 1'b0;
         irq_mask  <= 1'b0;
      end else if (wr_ctrl) begin
         step_mode <= host_wdata[CTRL_STEP_MODE];
         step_req  <= host_wdata[CTRL_STEP];
         irq_mask  <= host_wdata[CTRL_MASK];
      end else if (step_done) begin
         step_req  <= 1'b0;
      end
   end

   // R7
   status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end |=> stat_end);

   // R9
   step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(step_req) |-> $past(step_done || wr_ctrl));
endmodule

// File: rtl/anchor_disp_sched.sv
module anchor_disp_sched #(
   parameter int STORE_W = 2,
   parameter int Q_DEPTH = 4,
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_done,
   input  logic [1:0]         dec_kind,
   input  logic [STORE_W-1:0] dec_store,
   input  logic               seq_end,
   input  logic               seq_start,
   input  logic               fsync,
   input  logic               host_wr,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic [STORE_W-1:0] disp_store,
   output logic               disp_last,
   output logic               frozen,
   output logic               irq_n
);
   generate
      if (STORE_W < 2) begin : g_bad_store_w
         $error("STORE_W must index three frame stores");
      end
      if (Q_DEPTH < 2) begin : g_bad_depth
         $error("Q_DEPTH must be at least 2");
      end
      if (DATA_W < 3) begin : g_bad_data_w
         $error("DATA_W must hold the three control bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic               rel_push;
   logic [STORE_W-1:0] rel_store;
   logic               q_pop, q_empty;
   logic [STORE_W-1:0] q_head;
   logic               step_mode, step_req, step_done;

   ads_anchor_hold #(.STORE_W(STORE_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .dec_done(dec_done), .dec_kind(dec_kind), .dec_store(dec_store),
      .seq_end(seq_end),
      .rel_push(rel_push), .rel_store(rel_store)
   );

   ads_ready_fifo #(.STORE_W(STORE_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(rel_push), .push_data(rel_store),
      .pop(q_pop), .head(q_head), .empty(q_empty)
   );

   ads_field_seq #(.STORE_W(STORE_W)) u_fields (
      .clk(clk), .rst_n(rst_n),
      .fsync(fsync), .q_empty(q_empty), .q_head(q_head), .q_push(rel_push),
      .seq_end(seq_end), .seq_start(seq_start),
      .step_mode(step_mode), .step_req(step_req),
      .q_pop(q_pop), .step_done(step_done),
      .disp_store(disp_store), .disp_last(disp_last), .frozen(frozen)
   );

   ads_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .seq_end(seq_end), .step_done(step_done),
      .host_rdata(host_rdata),
      .step_mode(step_mode), .step_req(step_req), .irq_n(irq_n)
   );

   // R2
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dec_done, seq_end, seq_start}) <= 1);
endmodule

// File: tb/anchor_disp_sched_test.sv
module anchor_disp_sched_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dec_done = 1'b0;
   logic [1:0] dec_kind = 2'd0;
   logic [1:0] dec_store = 2'd0;
   logic       seq_end = 1'b0, seq_start = 1'b0, fsync = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic [1:0] disp_store;
   logic       disp_last, frozen, irq_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   anchor_disp_sched uut (
      .clk(clk), .rst_n(rst_n), .dec_done(dec_done), .dec_kind(dec_kind),
      .dec_store(dec_store), .seq_end(seq_end), .seq_start(seq_start),
      .fsync(fsync), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .disp_store(disp_store), .disp_last(disp_last), .frozen(frozen),
      .irq_n(irq_n)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic decode(input logic [1:0] kind, input logic [1:0] store);
      dec_done = 1'b1; dec_kind = kind; dec_store = store;
      @(negedge clk);
      dec_done = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_fsync();
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      @(negedge clk);
   endtask

   task automatic frame(input string req, input int exp_store);
      pulse_fsync();
      check({req, " first field store"}, disp_store, exp_store);
      check({req, " first field flag"}, disp_last, 0);
      pulse_fsync();
      check({req, " last field store"}, disp_store, exp_store);
      check({req, " last field flag"}, disp_last, 1);
   endtask

   task automatic reg_write(input logic [1:0] addr, input logic [7:0] data);
      host_wr = 1'b1; host_addr = addr; host_wdata = data;
      @(negedge clk);
      host_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic reg_read(input logic [1:0] addr, output int data);
      host_addr = addr;
      #1 data = int'(host_rdata);
      @(negedge clk);
   endtask

   task automatic pulse_end();
      seq_end = 1'b1;
      @(negedge clk);
      seq_end = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      seq_start = 1'b1;
      @(negedge clk);
      seq_start = 1'b0;
      @(negedge clk);
   endtask

   // R10
   task automatic test_reset();
      int v;
      do_reset();
      check("R10 store", disp_store, 0);
      check("R10 last flag", disp_last, 1);
      check("R10 frozen", frozen, 0);
      check("R10 irq_n", irq_n, 1);
      reg_read(2'd0, v); check("R10 status", v, 0);
      reg_read(2'd1, v); check("R10 ctrl", v, 0);
   endtask

   // R1 R2 R3: reordering and anchor hold
   task automatic test_order();
      do_reset();
      decode(2'd0, 2'd0);
      decode(2'd1, 2'd1);
      decode(2'd2, 2'd2);
      decode(2'd3, 2'd3);           // ignored kind
      decode(2'd2, 2'd2);
      decode(2'd1, 2'd0);
      check("R3 no change without fsync", disp_store, 0);
      frame("R1 I shown after next anchor", 0);
      frame("R2 first B", 2);
      frame("R2 second B", 2);
      frame("R1 P released by later P", 1);
      frame("R1 newest anchor still held", 1);
      check("R5 not frozen in normal run", frozen, 0);
   endtask

   // R4 R5 R6 R7 R8: end flush, freeze, restart, interrupt
   task automatic test_end();
      int v;
      do_reset();
      decode(2'd0, 2'd1);
      decode(2'd1, 2'd0);
      frame("R1 I shown", 1);
      frame("R1 P held before end", 1);
      pulse_end();
      check("R8 irq after end", irq_n, 0);
      reg_read(2'd0, v); check("R7 status set", v, 1);
      frame("R4 held anchor flushed", 0);
      check("R5 frozen after flush", frozen, 1);
      decode(2'd0, 2'd1);
      decode(2'd1, 2'd0);
      frame("R5 store held while frozen", 0);
      check("R5 still frozen", frozen, 1);
      pulse_start();
      check("R6 freeze cleared", frozen, 0);
      frame("R6 new sequence shown", 1);
      reg_write(2'd0, 8'h00);
      check("R7 write of 0 keeps irq", irq_n, 0);
      reg_write(2'd0, 8'h01);
      check("R7 W1C clears irq", irq_n, 1);
      reg_read(2'd0, v); check("R7 status cleared", v, 0);
   endtask

   // R4 R5: end with nothing held freezes at once
   task automatic test_end_empty();
      do_reset();
      pulse_end();
      check("R5 freeze with nothing pending", frozen, 1);
      decode(2'd0, 2'd1);
      decode(2'd1, 2'd0);
      frame("R5 frozen store unchanged", 0);
   endtask

   // R7 R8: mask and set-wins
   task automatic test_mask();
      int v;
      do_reset();
      reg_write(2'd1, 8'h04);
      pulse_end();
      check("R8 masked irq", irq_n, 1);
      reg_read(2'd0, v); check("R7 status under mask", v, 1);
      reg_write(2'd1, 8'h00);
      check("R8 unmasked irq", irq_n, 0);
      reg_write(2'd0, 8'h01);
      check("R8 cleared", irq_n, 1);
      host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h01; seq_end = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; seq_end = 1'b0;
      @(negedge clk);
      check("R7 set wins over clear", irq_n, 0);
   endtask

   // R9: single step
   task automatic test_step();
      int v;
      do_reset();
      reg_write(2'd1, 8'h01);
      decode(2'd0, 2'd1);
      decode(2'd1, 2'd0);
      decode(2'd2, 2'd2);
      decode(2'd1, 2'd1);
      frame("R9 step mode holds", 0);
      reg_write(2'd1, 8'h03);
      reg_read(2'd1, v); check("R9 step bit set", v, 3);
      frame("R9 one step", 1);
      reg_read(2'd1, v); check("R9 step self-cleared", v, 1);
      frame("R9 no second advance", 1);
      reg_write(2'd1, 8'h03);
      frame("R9 second step", 2);
      reg_write(2'd1, 8'h02);
      reg_read(2'd1, v); check("R9 step ignored w/o mode", v, 2);
      frame("R9 mode off runs", 0);
      reg_read(2'd1, v); check("R9 bit untouched w/o mode", v, 2);
   endtask

   initial begin
      test_reset();
      test_order();
      test_end();
      test_end_empty();
      test_mask();
      test_step();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule